// File: doc/BRIEF.md
# Descriptor-Driven Request/Completion Queue Controller

This block takes work from software as a single register write: the offset of a request inside request-queue memory. Offsets go into one hardware FIFO that every request queue shares. When the block is idle and the attached compute engine reports that it is idle, the block pops the oldest offset. It reads four descriptor words from memory and checks their opcodes. It streams the input words from memory into the engine and pulses the engine's start. After the engine signals done, it copies the result words back to memory.

Every request ends with one completion record. The block writes the record into a ring in memory and raises a level interrupt that stays high until software moves the consumer index up to the producer index. A request with a malformed descriptor sequence bypasses the engine and still gets a completion record, which carries an error status.

The control state machine has nine states: IDLE, FETCH, CHECK, LOAD, KICK, WAIT, STORE, RING and POST. Its transitions are:

- IDLE to FETCH when the FIFO holds an offset and `eng_idle` is high. The offset is popped on this transition.
- FETCH to CHECK after the fourth descriptor read is acknowledged.
- CHECK to LOAD when all four opcodes are valid. CHECK to RING when any opcode is wrong.
- LOAD to KICK when every input word has been delivered.
- KICK to WAIT unconditionally. KICK lasts one cycle, and `eng_start` is high during it.
- WAIT to STORE on `eng_done`.
- STORE to RING when every output word has been written.
- RING to POST when the ring has a free slot.
- POST to IDLE when the write of the completion record is acknowledged.

Top module: `rqcq_ctrl`

## Requirements
- R1: A register write to address 0 pushes `reg_wdata[15:0]` as a request offset into the shared FIFO. Requests complete in the order they were submitted.
- R2: A submit write that arrives while the FIFO holds `FIFO_DEPTH` offsets is dropped and sets `ovf_flag`. The flag stays set until a register write to address 5 clears it.
- R3: An offset is popped only when the controller is in IDLE and `eng_idle` is high. While `eng_idle` is low, no memory access starts.
- R4: Descriptor k, for k = 0 to 3, is read from word address `rq_base + offset + k`. `rq_base` is written through register address 1. Each descriptor is one 64-bit word whose opcode sits in bits [63:60]. Descriptor k must carry opcode k+1: START = 1, input transfer = 2, output transfer = 3, NOTIFY = 4.
- R5: Field layout and data movement:
  - A transfer descriptor holds the word address in bits [47:16] and the word count in bits [15:0].
  - Every input word reaches the engine on `eng_in_we` before the single-cycle `eng_start` pulse. During that pulse, `eng_cmd` carries START bits [31:0].
  - Output word k is written to `out_addr + k` after `eng_done`, taking the value of `eng_out_data` while `eng_out_idx` equals k.
- R6: The completion record is written to word `cq_base + prod`. Its value is `{32'b0, id[15:0], 8'h00, status[7:0]}`, where id is NOTIFY bits [15:0] and status is 0 on success. `cq_base` is written through register address 2.
- R7: If any descriptor opcode is wrong, the engine is not started and no data words move. The status is then `8'h80 | k`, where k is the first bad descriptor.
- R8: The ring is full when `(prod+1) mod depth == cons`. While it is full, the record write stalls, and it resumes once software writes a new consumer index to address 4.
- R9: After writing slot depth-1, the producer index wraps to 0. The depth is written through register address 3 and resets to 8.
- R10: `irq` is high exactly while the producer index differs from the consumer index. It is 0 after reset.
- R11: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack`. Read data is taken in the cycle of `mem_ack`.
- R12: Writing the ring base or the ring depth resets both the producer and the consumer index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| ovf_flag | output | 1 | Sticky submit-overflow flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| eng_idle | input | 1 | Engine available for a new request |
| eng_in_we | output | 1 | Input word strobe to engine |
| eng_in_data | output | 64 | Input word to engine |
| eng_start | output | 1 | One-cycle engine start |
| eng_cmd | output | 32 | Command operand from START descriptor |
| eng_done | input | 1 | Engine finished pulse |
| eng_out_idx | output | 16 | Index of result word requested |
| eng_out_data | input | 64 | Result word at eng_out_idx |
| irq | output | 1 | Level completion interrupt |

## Verification
The hardest situation to reach from the ports is a request that has been fully processed while the ring is full. The record write must be held in the RING state while software has not yet advanced the consumer index. To get there, the stimulus shrinks the ring to three slots and submits three requests without acknowledging any of them. It then confirms that only two records appear and that the third waits. It then writes the consumer index and watches the third record land in the last slot, followed by a fourth record in slot 0. The drop path is reached the same way: the engine is held unavailable while the bench submits one more offset than the FIFO can hold.

// File: rtl/rqcq_pkg.sv
package rqcq_pkg;
    localparam int WORD_W = 64;
    localparam int ADDR_W = 32;

    localparam logic [3:0] OPC_START = 4'd1;
    localparam logic [3:0] OPC_IN    = 4'd2;
    localparam logic [3:0] OPC_OUT   = 4'd3;
    localparam logic [3:0] OPC_NOTE  = 4'd4;

    localparam logic [2:0] RA_SUBMIT  = 3'd0;
    localparam logic [2:0] RA_RQBASE  = 3'd1;
    localparam logic [2:0] RA_CQBASE  = 3'd2;
    localparam logic [2:0] RA_CQDEPTH = 3'd3;
    localparam logic [2:0] RA_CQCONS  = 3'd4;
    localparam logic [2:0] RA_OVFCLR  = 3'd5;

    localparam logic [7:0] STAT_OK    = 8'h00;
    localparam logic [7:0] STAT_BADOP = 8'h80;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_LOAD,
        ST_KICK,
        ST_WAIT,
        ST_STORE,
        ST_RING,
        ST_POST
    } ctl_state_e;

    function automatic logic [3:0] desc_op(input logic [WORD_W-1:0] d);
        return d[63:60];
    endfunction

    function automatic logic [ADDR_W-1:0] xfer_addr(input logic [WORD_W-1:0] d);
        return d[47:16];
    endfunction

    function automatic logic [15:0] xfer_cnt(input logic [WORD_W-1:0] d);
        return d[15:0];
    endfunction
endpackage

// File: rtl/rqcq_fifo.sv
module rqcq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] CNT_MAX = (PW+1)'(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [PW:0]   cnt;
    logic          accept, take;

    assign full   = (cnt == CNT_MAX);
    assign empty  = (cnt == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign dout   = slots[rp];

    always_ff @(posedge clk) begin
        if (accept) begin
            slots[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (accept) wp <= wp + 1'b1;
            if (take)   rp <= rp + 1'b1;
            unique case ({accept, take})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R2
    fifo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rqcq_ring.sv
module rqcq_ring #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] depth,
    input  logic          cons_we,
    input  logic [IW-1:0] cons_wdata,
    input  logic          adv,
    output logic [IW-1:0] prod,
    output logic          full,
    output logic          irq
);
    logic [IW-1:0] prod_q, cons_q, prod_nxt;

    assign prod_nxt = (prod_q == depth - 1'b1) ? '0 : prod_q + 1'b1;
    assign full     = (prod_nxt == cons_q);
    assign irq      = (prod_q != cons_q);
    assign prod     = prod_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod_q <= '0;
            cons_q <= '0;
        end else begin
            if (adv)     prod_q <= prod_nxt;
            if (cons_we) cons_q <= cons_wdata;
        end
    end

    // R8
    ring_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !full);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !cons_we) |=> irq);
endmodule

// File: rtl/rqcq_ctrl.sv
module rqcq_ctrl
    import rqcq_pkg::*;
#(
    parameter int OFF_W          = 16,
    parameter int FIFO_DEPTH     = 4,
    parameter int IW             = 16,
    parameter int RING_DEPTH_RST = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic        ovf_flag,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [63:0] mem_wdata,
    input  logic [63:0] mem_rdata,
    input  logic        mem_ack,
    input  logic        eng_idle,
    output logic        eng_in_we,
    output logic [63:0] eng_in_data,
    output logic        eng_start,
    output logic [31:0] eng_cmd,
    input  logic        eng_done,
    output logic [15:0] eng_out_idx,
    input  logic [63:0] eng_out_data,
    output logic        irq
);
    localparam int NDESC = 4;
    localparam int DI_W  = $clog2(NDESC);

    ctl_state_e           state, state_nxt;
    logic [ADDR_W-1:0]    rq_base, cq_base;
    logic [IW-1:0]        cq_depth;
    logic                 ovf_q;
    logic [OFF_W-1:0]     cur_off;
    logic [DI_W-1:0]      didx;
    logic [WORD_W-1:0]    desc [NDESC];
    logic [15:0]          wcnt;
    logic [7:0]           stat;

    logic                 sub_we, fifo_full, fifo_empty, fifo_pop;
    logic [OFF_W-1:0]     fifo_dout;
    logic                 ring_clr, cons_we, ring_full, ring_adv;
    logic [IW-1:0]        prod;
    logic                 bad_any;
    logic [DI_W-1:0]      bad_idx;
    logic                 xfer_ack;

    logic [ADDR_W-1:0]    in_addr, out_addr;
    logic [15:0]          in_cnt, out_cnt, req_id;

    assign in_addr  = xfer_addr(desc[1]);
    assign in_cnt   = xfer_cnt(desc[1]);
    assign out_addr = xfer_addr(desc[2]);
    assign out_cnt  = xfer_cnt(desc[2]);
    assign req_id   = desc[3][15:0];

    assign sub_we   = reg_we && (reg_addr == RA_SUBMIT);
    assign ring_clr = reg_we && ((reg_addr == RA_CQBASE) || (reg_addr == RA_CQDEPTH));
    assign cons_we  = reg_we && (reg_addr == RA_CQCONS);
    assign xfer_ack = mem_req && mem_ack;

    rqcq_fifo #(.W(OFF_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sub_we),
        .din   (reg_wdata[OFF_W-1:0]),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    rqcq_ring #(.IW(IW)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ring_clr),
        .depth      (cq_depth),
        .cons_we    (cons_we),
        .cons_wdata (reg_wdata[IW-1:0]),
        .adv        (ring_adv),
        .prod       (prod),
        .full       (ring_full),
        .irq        (irq)
    );

    // first descriptor whose opcode is not the one its slot calls for
    always_comb begin
        bad_any = 1'b0;
        bad_idx = '0;
        for (int i = NDESC - 1; i >= 0; i--) begin
            if (desc_op(desc[i]) != 4'(i + 1)) begin
                bad_any = 1'b1;
                bad_idx = DI_W'(i);
            end
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_base  <= '0;
            cq_base  <= '0;
            cq_depth <= IW'(RING_DEPTH_RST);
            ovf_q    <= 1'b0;
        end else begin
            if (reg_we && reg_addr == RA_RQBASE)  rq_base  <= reg_wdata;
            if (reg_we && reg_addr == RA_CQBASE)  cq_base  <= reg_wdata;
            if (reg_we && reg_addr == RA_CQDEPTH) cq_depth <= reg_wdata[IW-1:0];
            if (sub_we && fifo_full)
                ovf_q <= 1'b1;
            else if (reg_we && reg_addr == RA_OVFCLR)
                ovf_q <= 1'b0;
        end
    end
    assign ovf_flag = ovf_q;

    // state register and request datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_off <= '0;
            didx    <= '0;
            wcnt    <= '0;
            stat    <= STAT_OK;
            for (int i = 0; i < NDESC; i++) desc[i] <= '0;
        end else begin
            state <= state_nxt;
            unique case (state)
                ST_IDLE: begin
                    if (fifo_pop) begin
                        cur_off <= fifo_dout;
                        didx    <= '0;
                    end
                end
                ST_FETCH: begin
                    if (xfer_ack) begin
                        desc[didx] <= mem_rdata;
                        didx       <= didx + 1'b1;
                    end
                end
                ST_CHECK: begin
                    wcnt <= '0;
                    stat <= bad_any ? (STAT_BADOP | 8'(bad_idx)) : STAT_OK;
                end
                ST_LOAD, ST_STORE: begin
                    if (xfer_ack) wcnt <= wcnt + 1'b1;
                end
                ST_KICK: wcnt <= '0;
                default: ;
            endcase
        end
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (!fifo_empty && eng_idle) state_nxt = ST_FETCH;
            ST_FETCH: if (xfer_ack && didx == DI_W'(NDESC - 1)) state_nxt = ST_CHECK;
            ST_CHECK: state_nxt = bad_any ? ST_RING : ST_LOAD;
            ST_LOAD:  if (wcnt == in_cnt) state_nxt = ST_KICK;
            ST_KICK:  state_nxt = ST_WAIT;
            ST_WAIT:  if (eng_done) state_nxt = ST_STORE;
            ST_STORE: if (wcnt == out_cnt) state_nxt = ST_RING;
            ST_RING:  if (!ring_full) state_nxt = ST_POST;
            ST_POST:  if (xfer_ack) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fifo_pop  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        eng_in_we = 1'b0;
        eng_start = 1'b0;
        ring_adv  = 1'b0;
        unique case (state)
            ST_IDLE: fifo_pop = !fifo_empty && eng_idle;
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = rq_base + ADDR_W'(cur_off) + ADDR_W'(didx);
            end
            ST_LOAD: begin
                if (wcnt != in_cnt) begin
                    mem_req   = 1'b1;
                    mem_addr  = in_addr + ADDR_W'(wcnt);
                    eng_in_we = mem_ack;
                end
            end
            ST_KICK: eng_start = 1'b1;
            ST_STORE: begin
                if (wcnt != out_cnt) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = out_addr + ADDR_W'(wcnt);
                    mem_wdata = eng_out_data;
                end
            end
            ST_POST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cq_base + ADDR_W'(prod);
                mem_wdata = {32'b0, req_id, 8'h00, stat};
                ring_adv  = mem_ack;
            end
            default: ;
        endcase
    end

    assign eng_in_data = mem_rdata;
    assign eng_cmd     = desc[0][31:0];
    assign eng_out_idx = wcnt;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R2
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_we && fifo_full) |=> ovf_flag);

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_idle && state == ST_IDLE) |=> !mem_req);
endmodule

// File: tb/sim_rqcq_ctrl.sv
module sim_rqcq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        ovf_flag, mem_req, mem_we, eng_in_we, eng_start, irq;
    logic [31:0] mem_addr, eng_cmd;
    logic [63:0] mem_wdata, eng_in_data, eng_out_data;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        hold = 1'b0;
    logic        eng_done = 1'b0;
    logic [15:0] eng_out_idx;

    localparam logic [63:0] MASK = 64'h5A5A_0F0F_C3C3_9696;
    localparam int RQB = 16;
    localparam int CQB = 200;

    always #10 clk = ~clk;

    rqcq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ovf_flag(ovf_flag), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .eng_idle(!hold),
        .eng_in_we(eng_in_we), .eng_in_data(eng_in_data), .eng_start(eng_start),
        .eng_cmd(eng_cmd), .eng_done(eng_done), .eng_out_idx(eng_out_idx),
        .eng_out_data(eng_out_data), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int starts = 0;
    int bprod = 0;
    int bdepth = 8;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model with a backdoor write port for preloading
    logic [63:0] mem [0:255];
    logic        bd_we = 1'b0;
    logic [7:0]  bd_addr = '0;
    logic [63:0] bd_data = '0;

    always @(posedge clk) begin
        if (bd_we) mem[bd_addr] <= bd_data;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // stub engine
    logic [63:0] ebuf [0:15];
    int          ein = 0;
    int          dly = 0;
    logic [31:0] cmd_l = '0;
    assign eng_out_data = ebuf[eng_out_idx[3:0]] ^ MASK ^ {32'b0, cmd_l};

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_in_we) begin
            ebuf[ein[3:0]] <= eng_in_data;
            ein <= ein + 1;
        end
        if (eng_start) begin
            ein   <= 0;
            cmd_l <= eng_cmd;
            dly   <= 3;
        end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) eng_done <= 1'b1;
        end
    end

    // scoreboard queues
    logic [31:0] q_entry [$];
    bit          q_ok    [$];
    int          q_nin   [$];
    int          q_in    [$];
    int          q_out   [$];
    int          q_nout  [$];
    logic [31:0] q_cmd   [$];

    // monitor
    always @(negedge clk) begin
        if (rst_n && eng_start) begin
            starts++;
            if (q_ok.size() == 0) begin
                chk(1'b0, "R7 start with nothing pending", 64'(starts), 0);
            end else begin
                chk(q_ok[0], "R7 engine started for bad request", 1, 0);
                chk(ein == q_nin[0], "R5 inputs loaded before start", 64'(ein), 64'(q_nin[0]));
                chk(eng_cmd == q_cmd[0], "R5 command operand", 64'(eng_cmd), 64'(q_cmd[0]));
            end
        end
        if (rst_n && mem_req && mem_we && mem_ack && mem_addr >= CQB && mem_addr < CQB + 16) begin
            if (q_entry.size() == 0) begin
                chk(1'b0, "R1 unexpected completion", mem_wdata, 0);
            end else begin
                chk(mem_addr == 32'(CQB + bprod), "R9 ring slot", 64'(mem_addr), 64'(CQB + bprod));
                chk(mem_wdata == {32'b0, q_entry[0]}, "R6 completion record", mem_wdata, {32'b0, q_entry[0]});
                for (int k = 0; k < q_nout[0]; k++) begin
                    if (q_ok[0])
                        chk(mem[q_out[0] + k] == (mem[q_in[0] + k] ^ MASK ^ {32'b0, q_cmd[0]}),
                            "R5 output word", mem[q_out[0] + k], mem[q_in[0] + k] ^ MASK ^ {32'b0, q_cmd[0]});
                    else
                        chk(mem[q_out[0] + k] == (64'hDEAD_0000_0000_0000 | 64'(k)),
                            "R7 output untouched", mem[q_out[0] + k], 64'hDEAD_0000_0000_0000 | 64'(k));
                end
                void'(q_entry.pop_front()); void'(q_ok.pop_front()); void'(q_nin.pop_front());
                void'(q_in.pop_front()); void'(q_out.pop_front()); void'(q_nout.pop_front());
                void'(q_cmd.pop_front());
                bprod = (bprod + 1) % bdepth;
                done_cnt++;
            end
        end
    end

    task automatic poke(input int a, input logic [63:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = 8'(a); bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // driver: builds a request in memory, records expectations, submits it
    task automatic submit(input int off, input logic [15:0] id, input logic [31:0] cmd,
                          input int in_a, input int nin, input int out_a, input int nout,
                          input int bad_slot, input bit expect_it);
        logic [3:0] op [4];
        for (int i = 0; i < 4; i++) op[i] = (i == bad_slot) ? 4'hF : 4'(i + 1);
        poke(RQB + off + 0, {op[0], 28'h0, cmd});
        poke(RQB + off + 1, {op[1], 12'h0, 32'(in_a), 16'(nin)});
        poke(RQB + off + 2, {op[2], 12'h0, 32'(out_a), 16'(nout)});
        poke(RQB + off + 3, {op[3], 44'h0, id});
        for (int k = 0; k < nin; k++) poke(in_a + k, {id, 16'(k), 32'hBEEF_0000 + 32'(off)});
        for (int k = 0; k < nout; k++) poke(out_a + k, 64'hDEAD_0000_0000_0000 | 64'(k));
        if (expect_it) begin
            q_entry.push_back({id, 8'h00, (bad_slot < 4) ? (8'h80 | 8'(bad_slot)) : 8'h00});
            q_ok.push_back(bad_slot >= 4);
            q_nin.push_back(nin); q_in.push_back(in_a);
            q_out.push_back(out_a); q_nout.push_back(nout); q_cmd.push_back(cmd);
        end
        wr(3'd0, 32'(off));
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && q_entry.size() != 0; i++) @(negedge clk);
        chk(q_entry.size() == 0, "R1 all requests completed", 64'(q_entry.size()), 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int s0, d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq low after reset", 64'(irq), 0);
        chk(ovf_flag == 1'b0, "R2 ovf low after reset", 64'(ovf_flag), 0);
        chk(mem_req == 1'b0, "R3 no access after reset", 64'(mem_req), 0);

        wr(3'd1, RQB);
        wr(3'd2, CQB);
        bdepth = 8; bprod = 0;

        // R3: engine busy holds the request in the FIFO
        hold = 1'b1;
        submit(0, 16'h0011, 32'h0000_1111, 64, 3, 128, 2, 9, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req) chk(1'b0, "R3 access while engine busy", 64'(mem_req), 0);
        end
        chk(q_entry.size() == 1, "R3 request waits for engine", 64'(q_entry.size()), 1);
        hold = 1'b0;
        drain();

        // R1, R4, R5, R6: several shapes in submission order
        submit(4,  16'h0022, 32'h2222_0002, 72, 1, 136, 1, 9, 1);
        submit(8,  16'h0033, 32'h3333_0003, 80, 4, 144, 4, 9, 1);
        submit(12, 16'h0044, 32'h4444_0004, 88, 2, 152, 0, 9, 1);
        drain();
        chk(irq == 1'b1, "R10 irq while entries unacknowledged", 64'(irq), 1);
        wr(3'd4, 32'(bprod));
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq clears when consumer catches up", 64'(irq), 0);

        // R7: malformed descriptor sequences
        s0 = starts;
        submit(0, 16'h0055, 32'h5555_0005, 64, 2, 128, 2, 2, 1);
        submit(4, 16'h0066, 32'h6666_0006, 72, 2, 136, 2, 0, 1);
        drain();
        chk(starts == s0, "R7 engine not started", 64'(starts), 64'(s0));
        wr(3'd4, 32'(bprod));

        // R2: overflow of the shared FIFO
        hold = 1'b1;
        for (int i = 0; i < 5; i++)
            submit(4 * i, 16'h0070 + 16'(i), 32'h7000_0000 + 32'(i), 64 + 8 * i, 2,
                   128 + 8 * i, 2, 9, i < 4);
        @(negedge clk);
        chk(ovf_flag == 1'b1, "R2 ovf set on dropped submit", 64'(ovf_flag), 1);
        wr(3'd5, 0);
        chk(ovf_flag == 1'b0, "R2 ovf cleared", 64'(ovf_flag), 0);
        d0 = done_cnt;
        hold = 1'b0;
        drain();
        repeat (100) @(negedge clk);
        chk(done_cnt == d0 + 4, "R2 dropped request never completes", 64'(done_cnt), 64'(d0 + 4));

        // R12: depth write clears indices (entries left unacknowledged)
        chk(irq == 1'b1, "R10 irq pending before depth write", 64'(irq), 1);
        wr(3'd3, 3);
        bdepth = 3; bprod = 0;
        chk(irq == 1'b0, "R12 indices cleared by depth write", 64'(irq), 0);

        // R8: ring full stalls the record write
        d0 = done_cnt;
        submit(0, 16'h0081, 32'h8100_0000, 64, 1, 128, 1, 9, 1);
        submit(4, 16'h0082, 32'h8200_0000, 72, 1, 136, 1, 9, 1);
        submit(8, 16'h0083, 32'h8300_0000, 80, 1, 144, 1, 9, 1);
        repeat (300) @(negedge clk);
        chk(done_cnt == d0 + 2, "R8 only two records while ring full", 64'(done_cnt), 64'(d0 + 2));
        chk(q_entry.size() == 1, "R8 third record stalled", 64'(q_entry.size()), 1);
        wr(3'd4, 2);
        drain();
        chk(bprod == 0, "R9 producer wrapped", 64'(bprod), 0);

        // R9: next record lands in slot 0
        submit(12, 16'h0084, 32'h8400_0000, 88, 1, 152, 1, 9, 1);
        drain();
        chk(irq == 1'b1, "R10 irq with prod!=cons", 64'(irq), 1);
        wr(3'd4, 1);
        chk(irq == 1'b0, "R10 irq clears", 64'(irq), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=%0d exp=0", q_entry.size());
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule